// File: doc/BRIEF.md
# Single-Read Target for a 32-bit Synchronous Shared Bus

This block sits on a 32-bit synchronous multiplexed address/data bus as a target that only answers reads of a single data phase. It watches for the start of a cycle on the frame line. In the address phase it decodes the address and the command code. If the cycle is a memory read or an I/O read that falls inside its window, it claims the cycle on the device-select line one clock later. It leaves the data lines undriven for one turnaround clock, then optionally stalls for a programmable number of wait states. After that it presents the selected word of its local register file on the target-ready line. Once the word has moved, it releases every line it drove.

The shared pins are split into separate input, output and output-enable signals, so the pad ring builds the tri-state drivers. All control lines are active low and sampled on the rising clock edge. The register file is loaded through a simple local write port. The memory and I/O window bases and the wait-state count are static configuration inputs.

Top module: `pciReadTarget`

## Requirements
- R1: While reset is asserted and in the first clock after it, no output enable is active, and trdyN and devselN read high.
- R2: A memory read (command 4'b0110, adIn[1:0]=2'b00, adIn[31:6] equal to cfgMemBaseHi) or an I/O read (command 4'b0010, adIn[31:6] equal to cfgIoBaseHi) is claimed. The claim drives devselN low in the clock right after the address phase, well inside the 6-clock limit. The address phase is the first clock with frameN low after a clock with frameN high.
- R3: Any other command, or an address outside the selected window, leaves devselOe, trdyOe and adOe inactive for the whole cycle.
- R4: In the claiming clock the target does not drive the data lines (adOe low), which gives one turnaround clock.
- R5: trdyN falls exactly cfgWaitStates+1 clocks after devselN falls.
- R6: While trdyN is low, adOe is high and adOut carries register adIn[5:2] of the address phase. Byte k (bits 8k+7:8k) is zeroed when cbeN[k] is 1, meaning that byte is not enabled.
- R7: If irdyN is high while trdyN is low, trdyN stays low and the data stays on the bus until a clock in which both are low.
- R8: In the clock after the transfer clock, trdyN and devselN are driven high and adOe is low. In the clock after that, trdyOe and devselOe are low.
- R9: A clock with locWrEn high writes locWrData into register locWrIdx, and later reads of that index return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low reset |
| frameN | input | 1 | Cycle frame from the initiator, active low |
| irdyN | input | 1 | Initiator ready, active low |
| cbeN | input | 4 | Command in address phase, byte enables (active low) in data phase |
| adIn | input | 32 | Address/data lines as received |
| cfgMemBaseHi | input | 26 | Memory window base, address bits 31:6 |
| cfgIoBaseHi | input | 26 | I/O window base, address bits 31:6 |
| cfgWaitStates | input | 4 | Wait states inserted before target-ready |
| locWrEn | input | 1 | Local register write strobe |
| locWrIdx | input | 4 | Local register write index |
| locWrData | input | 32 | Local register write data |
| adOut | output | 32 | Read data to the address/data lines |
| adOe | output | 1 | Drive enable for adOut |
| trdyN | output | 1 | Target ready, active low |
| trdyOe | output | 1 | Drive enable for trdyN |
| devselN | output | 1 | Device select, active low |
| devselOe | output | 1 | Drive enable for devselN |

## Verification
Every clock, the assertions check that a claim comes one clock after an address phase with the data lines still undriven. They also check that the data lines are driven only while the cycle is claimed, that target-ready follows the claim after exactly the programmed number of waits, and that the release takes one driven-high clock and then tri-states. Only the bench scenarios can show which command and window pairs are claimed or ignored, that the returned word and its byte masking match the register contents, that target-ready holds through initiator stalls, and that local writes reach later reads.

// File: rtl/pciTgtPkg.sv
package pciTgtPkg;

  localparam logic [3:0] CMD_IO_READ  = 4'b0010;
  localparam logic [3:0] CMD_MEM_READ = 4'b0110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_WAIT,
    ST_DATA,
    ST_REL
  } tgtState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchAddr;
    logic loadWait;
    logic decWait;
  } dpStrobes_t;

endpackage

// File: rtl/pciTgtDatapath.sv
module pciTgtDatapath
  import pciTgtPkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int WAIT_W   = 4,
  localparam int IDX_W    = $clog2(NUM_REGS),
  localparam int BASE_LSB = IDX_W + 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobes_t           strobes,
  input  logic [31:0]          adIn,
  input  logic [3:0]           cbeN,
  input  logic [31:BASE_LSB]   cfgMemBaseHi,
  input  logic [31:BASE_LSB]   cfgIoBaseHi,
  input  logic [WAIT_W-1:0]    cfgWaitStates,
  input  logic                 locWrEn,
  input  logic [IDX_W-1:0]     locWrIdx,
  input  logic [31:0]          locWrData,
  output logic                 addrHit,
  output logic                 waitZero,
  output logic                 waitLast,
  output logic [31:0]          adOut
);

  logic [31:0]       regFile [NUM_REGS];
  logic [IDX_W-1:0]  idxQ;
  logic [WAIT_W-1:0] waitCnt;
  logic [31:0]       readWord;
  logic              memHit;
  logic              ioHit;

  // Local register file, written only from the local side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= '0;
    end else if (locWrEn) begin
      regFile[locWrIdx] <= locWrData;
    end
  end

  // Address decode for the two read spaces
  always_comb begin
    memHit  = (cbeN == CMD_MEM_READ) && (adIn[1:0] == 2'b00) &&
              (adIn[31:BASE_LSB] == cfgMemBaseHi);
    ioHit   = (cbeN == CMD_IO_READ) && (adIn[31:BASE_LSB] == cfgIoBaseHi);
    addrHit = memHit || ioHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ <= '0;
    end else if (strobes.latchAddr) begin
      idxQ <= adIn[BASE_LSB-1:2];
    end
  end

  // Wait-state counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (strobes.loadWait) begin
      waitCnt <= cfgWaitStates;
    end else if (strobes.decWait && (waitCnt != '0)) begin
      waitCnt <= waitCnt - 1'b1;
    end
  end

  assign waitZero = (waitCnt == '0);
  assign waitLast = (waitCnt == WAIT_W'(1));
  assign readWord = regFile[idxQ];

  // Byte masking by active-low enables
  for (genvar b = 0; b < 4; b++) begin : gByteLane
    assign adOut[8*b +: 8] = cbeN[b] ? 8'h00 : readWord[8*b +: 8];
  end

endmodule

// File: rtl/pciTgtCtrl.sv
module pciTgtCtrl
  import pciTgtPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameN,
  input  logic       irdyN,
  input  logic       addrHit,
  input  logic       waitZero,
  input  logic       waitLast,
  output dpStrobes_t strobes,
  output logic       adOe,
  output logic       trdyN,
  output logic       trdyOe,
  output logic       devselN,
  output logic       devselOe
);

  tgtState_e state;
  tgtState_e nextState;
  logic      lastFrameN;
  logic      addrPhase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      lastFrameN <= 1'b1;
    end else begin
      state      <= nextState;
      lastFrameN <= frameN;
    end
  end

  assign addrPhase = !frameN && lastFrameN;

  always_comb begin
    nextState = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: begin
        if (addrPhase && addrHit) begin
          nextState         = ST_TURN;
          strobes.latchAddr = 1'b1;
          strobes.loadWait  = 1'b1;
        end
      end
      ST_TURN: nextState = waitZero ? ST_DATA : ST_WAIT;
      ST_WAIT: begin
        strobes.decWait = 1'b1;
        if (waitLast) nextState = ST_DATA;
      end
      ST_DATA: if (!irdyN) nextState = ST_REL;
      ST_REL:  nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    devselOe = (state != ST_IDLE);
    trdyOe   = (state != ST_IDLE);
    devselN  = !((state == ST_TURN) || (state == ST_WAIT) || (state == ST_DATA));
    trdyN    = (state != ST_DATA);
    adOe     = (state == ST_DATA);
  end

endmodule

// File: rtl/pciReadTarget.sv
module pciReadTarget
  import pciTgtPkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int WAIT_W   = 4,
  localparam int IDX_W    = $clog2(NUM_REGS),
  localparam int BASE_LSB = IDX_W + 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                frameN,
  input  logic                irdyN,
  input  logic [3:0]          cbeN,
  input  logic [31:0]         adIn,
  input  logic [31:BASE_LSB]  cfgMemBaseHi,
  input  logic [31:BASE_LSB]  cfgIoBaseHi,
  input  logic [WAIT_W-1:0]   cfgWaitStates,
  input  logic                locWrEn,
  input  logic [IDX_W-1:0]    locWrIdx,
  input  logic [31:0]         locWrData,
  output logic [31:0]         adOut,
  output logic                adOe,
  output logic                trdyN,
  output logic                trdyOe,
  output logic                devselN,
  output logic                devselOe
);

  dpStrobes_t strobes;
  logic       addrHit;
  logic       waitZero;
  logic       waitLast;

  pciTgtCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .frameN   (frameN),
    .irdyN    (irdyN),
    .addrHit  (addrHit),
    .waitZero (waitZero),
    .waitLast (waitLast),
    .strobes  (strobes),
    .adOe     (adOe),
    .trdyN    (trdyN),
    .trdyOe   (trdyOe),
    .devselN  (devselN),
    .devselOe (devselOe)
  );

  pciTgtDatapath #(
    .NUM_REGS (NUM_REGS),
    .WAIT_W   (WAIT_W)
  ) uDp (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .adIn          (adIn),
    .cbeN          (cbeN),
    .cfgMemBaseHi  (cfgMemBaseHi),
    .cfgIoBaseHi   (cfgIoBaseHi),
    .cfgWaitStates (cfgWaitStates),
    .locWrEn       (locWrEn),
    .locWrIdx      (locWrIdx),
    .locWrData     (locWrData),
    .addrHit       (addrHit),
    .waitZero      (waitZero),
    .waitLast      (waitLast),
    .adOut         (adOut)
  );

endmodule

// File: rtl/pciTgtChecker.sv
module pciTgtChecker #(
  parameter int WAIT_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameN,
  input logic              irdyN,
  input logic [WAIT_W-1:0] cfgWaitStates,
  input logic              adOe,
  input logic              trdyN,
  input logic              trdyOe,
  input logic              devselN,
  input logic              devselOe
);

  logic              prevFrameN;
  logic [WAIT_W-1:0] wsSnap;
  logic [WAIT_W:0]   claimAge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevFrameN <= 1'b1;
      wsSnap     <= '0;
      claimAge   <= '0;
    end else begin
      prevFrameN <= frameN;
      if (prevFrameN && !frameN) wsSnap <= cfgWaitStates;
      if (devselOe && !devselN && trdyN) claimAge <= claimAge + 1'b1;
      else                               claimAge <= '0;
    end
  end

  a_r2_claim_after_addr: assert property (@(posedge clk) disable iff (!rstN)
    $fell(devselN) |-> ($past(frameN) == 1'b0 && $past(prevFrameN) == 1'b1));

  a_r3_ad_only_when_claimed: assert property (@(posedge clk) disable iff (!rstN)
    adOe |-> (devselOe && !devselN));

  a_r4_turnaround: assert property (@(posedge clk) disable iff (!rstN)
    $fell(devselN) |-> !adOe);

  a_r5_wait_count: assert property (@(posedge clk) disable iff (!rstN)
    $fell(trdyN) |-> (claimAge == ({1'b0, wsSnap} + 1'b1)));

  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!trdyN && irdyN) |=> !trdyN);

  a_r8_release_high: assert property (@(posedge clk) disable iff (!rstN)
    (!trdyN && !irdyN) |=> (trdyN && devselN && trdyOe && devselOe && !adOe));

  a_r8_tristate: assert property (@(posedge clk) disable iff (!rstN)
    (devselOe && devselN) |=> (!devselOe && !trdyOe));

endmodule

bind pciReadTarget pciTgtChecker #(.WAIT_W(WAIT_W)) uChk (
  .clk           (clk),
  .rstN          (rstN),
  .frameN        (frameN),
  .irdyN         (irdyN),
  .cfgWaitStates (cfgWaitStates),
  .adOe          (adOe),
  .trdyN         (trdyN),
  .trdyOe        (trdyOe),
  .devselN       (devselN),
  .devselOe      (devselOe)
);

// File: tb/tb_pciReadTarget.sv
module tb_pciReadTarget;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MEM_BASE = 32'h4000_0000;
  localparam logic [31:0] IO_BASE  = 32'h0000_1000;

  typedef struct packed {
    logic [3:0]  cmd;
    logic [31:0] addr;
    logic [3:0]  ws;
    logic [3:0]  be;
    logic [3:0]  irdyDly;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{4'h6, 32'h4000_0000, 4'd0,  4'b0000, 4'd0},
    '{4'h6, 32'h4000_0014, 4'd2,  4'b0000, 4'd0},
    '{4'h2, 32'h0000_1008, 4'd0,  4'b1010, 4'd0},
    '{4'h2, 32'h0000_103C, 4'd3,  4'b0001, 4'd6},
    '{4'h7, 32'h4000_0000, 4'd0,  4'b0000, 4'd0},
    '{4'h6, 32'h4000_0040, 4'd0,  4'b0000, 4'd0},
    '{4'h2, 32'h4000_0004, 4'd0,  4'b0000, 4'd0},
    '{4'h6, 32'h0000_1000, 4'd0,  4'b0000, 4'd0},
    '{4'hA, 32'h4000_0000, 4'd0,  4'b0000, 4'd0},
    '{4'h6, 32'h4000_003C, 4'd5,  4'b1111, 4'd1},
    '{4'h6, 32'h4000_0020, 4'd15, 4'b0110, 4'd0}
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        frameN, irdyN;
  logic [3:0]  cbeN;
  logic [31:0] adIn;
  logic [3:0]  cfgWaitStates;
  logic        locWrEn;
  logic [3:0]  locWrIdx;
  logic [31:0] locWrData;
  logic [31:0] adOut;
  logic        adOe, trdyN, trdyOe, devselN, devselOe;

  logic [31:0] model [16];
  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pciReadTarget dut (
    .clk           (clk),
    .rstN          (rstN),
    .frameN        (frameN),
    .irdyN         (irdyN),
    .cbeN          (cbeN),
    .adIn          (adIn),
    .cfgMemBaseHi  (MEM_BASE[31:6]),
    .cfgIoBaseHi   (IO_BASE[31:6]),
    .cfgWaitStates (cfgWaitStates),
    .locWrEn       (locWrEn),
    .locWrIdx      (locWrIdx),
    .locWrData     (locWrData),
    .adOut         (adOut),
    .adOe          (adOe),
    .trdyN         (trdyN),
    .trdyOe        (trdyOe),
    .devselN       (devselN),
    .devselOe      (devselOe)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] maskBytes(input logic [31:0] w, input logic [3:0] be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = be[b] ? 8'h00 : w[8*b +: 8];
    return r;
  endfunction

  function automatic bit expectHit(input vec_t v);
    bit memOk = (v.cmd == 4'h6) && (v.addr[1:0] == 2'b00) && (v.addr[31:6] == MEM_BASE[31:6]);
    bit ioOk  = (v.cmd == 4'h2) && (v.addr[31:6] == IO_BASE[31:6]);
    return memOk || ioOk;
  endfunction

  task automatic localWrite(input logic [3:0] idx, input logic [31:0] data);
    @(negedge clk);
    locWrEn = 1'b1; locWrIdx = idx; locWrData = data;
    @(negedge clk);
    locWrEn = 1'b0;
    model[idx] = data;
  endtask

  task automatic runTxn(input vec_t v);
    bit hit = expectHit(v);
    logic [31:0] expWord = maskBytes(model[v.addr[5:2]], v.be);
    int firstTrdy = 0;
    bit moved = 1'b0;
    @(negedge clk);
    cfgWaitStates = v.ws; frameN = 1'b0; adIn = v.addr; cbeN = v.cmd; irdyN = 1'b1;
    @(negedge clk);
    frameN = 1'b1; cbeN = v.be; adIn = '0; irdyN = (v.irdyDly != 0);
    if (hit) begin
      check(devselOe && !devselN, "R2 claim one clock after address phase", {31'b0, devselN}, 32'h0);
      check(!adOe, "R4 no AD drive in turnaround clock", {31'b0, adOe}, 32'h0);
    end else begin
      check(!devselOe && !trdyOe && !adOe, "R3 unclaimed command or address",
            {29'b0, devselOe, trdyOe, adOe}, 32'h0);
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        check(!devselOe && !trdyOe && !adOe, "R3 stays idle on miss",
              {29'b0, devselOe, trdyOe, adOe}, 32'h0);
      end
      return;
    end
    for (int k = 2; k < 40 && !moved; k++) begin
      @(negedge clk);
      irdyN = (k < 1 + int'(v.irdyDly));
      if (!trdyN) begin
        if (firstTrdy == 0) begin
          firstTrdy = k;
          check(k == int'(v.ws) + 2, "R5 wait-state count", k, int'(v.ws) + 2);
        end
        check(adOe && adOut == expWord, "R6 read data and byte masking", adOut, expWord);
        if (!irdyN) moved = 1'b1;
      end else if (firstTrdy != 0) begin
        check(1'b0, "R7 trdy dropped before transfer", {31'b0, trdyN}, 32'h0);
      end
    end
    if (v.irdyDly > v.ws + 1)
      check(moved, "R7 held through initiator stall", {31'b0, moved}, 32'h1);
    @(negedge clk);
    irdyN = 1'b1;
    check(trdyOe && devselOe && trdyN && devselN && !adOe, "R8 driven high for one clock",
          {27'b0, trdyOe, devselOe, trdyN, devselN, adOe}, 32'h1E);
    @(negedge clk);
    check(!trdyOe && !devselOe, "R8 tri-stated afterwards", {30'b0, trdyOe, devselOe}, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    if (!done) $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; frameN = 1'b1; irdyN = 1'b1; cbeN = 4'hF; adIn = '0;
    cfgWaitStates = '0; locWrEn = 1'b0; locWrIdx = '0; locWrData = '0;
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    check(!adOe && !trdyOe && !devselOe && trdyN && devselN, "R1 reset state",
          {27'b0, adOe, trdyOe, devselOe, trdyN, devselN}, 32'h3);
    rstN = 1'b1;
    @(negedge clk);
    check(!adOe && !trdyOe && !devselOe && trdyN && devselN, "R1 first clock after reset",
          {27'b0, adOe, trdyOe, devselOe, trdyN, devselN}, 32'h3);

    for (int i = 0; i < 16; i++)
      localWrite(4'(i), 32'h1122_3344 ^ (32'(i) * 32'h0103_0507));

    for (int i = 0; i < NVEC; i++) runTxn(VECS[i]);

    // R9: overwrite a register through the local port and read it back
    localWrite(4'd5, 32'hDEAD_BEEF);
    runTxn('{4'h6, 32'h4000_0014, 4'd1, 4'b0000, 4'd0});
    check(model[5] == 32'hDEAD_BEEF, "R9 local write model", model[5], 32'hDEAD_BEEF);

    // Back-to-back claims with different spaces and waits
    runTxn('{4'h2, 32'h0000_1000, 4'd1, 4'b1100, 4'd2});
    runTxn('{4'h6, 32'h4000_0004, 4'd0, 4'b0011, 4'd0});

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule